// File: doc/BRIEF.md
# Salsa20 Core Iterative Engine

This block computes the Salsa20 core function: sixteen 32-bit words are mixed over a selectable number of rounds, and the original words are then added back. A host presents the whole 512-bit input block and a round count in parallel and pulses `start`. The block captures both and works through the rounds without further help. When it has finished, it raises `done` for one cycle, and the 512-bit result appears on `state_out`, where it stays until the next result.

Internally the sixteen words are kept in a diagonal layout: four lanes of four words. In this layout a single array of four quarter-round units performs the column half-round. A second pass of the same array, fed with lanes 1 to 3 rotated by their lane index, performs the row half-round. One full double round therefore completes every clock. Keystream combining, nonce and counter formatting, and key expansion are handled outside this block.

The controller is a three-state machine:
- `S_IDLE` waits for `start` and captures the inputs (transition IDLE→RUN).
- `S_RUN` applies one double round per cycle and stays in place while more than one double round is left. It moves on once the last double round has been applied (RUN→FINISH).
- `S_FINISH` restores word order, adds the captured input, registers the result, raises `done` and returns to idle (FINISH→IDLE).

Top module: `salsa_core_engine`

## Requirements
- R1: While reset is held and after it is released, `busy` and `done` are 0 and `state_out` is all zeros until the first result.
- R2: For a round count of 20, the result equals the Salsa20 core. The quarter round on (a,b,c,d) is b^=rotl(a+d,7), c^=rotl(b+a,9), d^=rotl(c+b,13), a^=rotl(d+c,18), with all sums taken modulo 2^32. Column quarter rounds act on words (0,4,8,12), (5,9,13,1), (10,14,2,6) and (15,3,7,11). Row quarter rounds act on words (0,1,2,3), (5,6,7,4), (10,11,8,9) and (15,12,13,14). Each double round is one column pass followed by one row pass. Every output word is the mixed word plus the input word of the same index, modulo 2^32.
- R3: Round counts 8 and 12 give the Salsa20/8 and Salsa20/12 cores, with 4 and 6 double rounds respectively.
- R4: Any round count other than 8, 12 or 20 (for example 0, 7, 10 or 31) behaves exactly like 20.
- R5: If `start` is sampled in idle in cycle 0, then `busy` is 1 in cycles 1 through R/2+1, and `done` is 1 only in cycle R/2+2, for a single cycle.
- R6: A `start` sampled while `busy` is 1 has no effect, and the run in progress finishes with the inputs it captured. In the cycle where `done` is 1, the block is idle and accepts a new `start`.
- R7: `state_out` changes only together with a `done` pulse, and holds its value between pulses.
- R8: Changes to `state_in` and `rounds` after the `start` cycle do not affect the result of the run in progress.
- R9: Word i of both the input and the output occupies bits [32i+31:32i].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a computation when idle |
| rounds | input | CNT_W (5) | Round count: 8, 12 or 20; other values select 20 |
| state_in | input | 512 | Sixteen input words, word i at [32i+31:32i] |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle pulse marking a new result |
| state_out | output | 512 | Sixteen result words, held until the next result |

## Verification
The bound checker watches the control handshake on every cycle. It confirms that `done` lasts a single cycle, that `done` only follows a busy interval and never overlaps it, that an accepted `start` raises `busy`, that idle persists without `start`, and that `state_out` moves only with `done`. The arithmetic cannot be checked that way. Correct mixing, round-count selection and clamping, word order, and immunity to input changes during a run all show up only in the bench's scenarios, where an independent word-indexed model predicts `busy`, `done` and `state_out` every cycle. Those scenarios include the all-zero published vector and a quarter-round vector that checks the model itself.

// File: rtl/salsa_pkg.sv
package salsa_pkg;
    localparam int WORD_W  = 32;
    localparam int LANES   = 4;
    localparam int WORDS   = LANES * LANES;
    localparam int BLK_W   = WORDS * WORD_W;

    typedef logic [WORD_W-1:0] word_t;
    typedef word_t [LANES-1:0] lane_t;
    typedef lane_t [LANES-1:0] grid_t;

    function automatic word_t rotl(input word_t x, input int unsigned n);
        return (x << n) | (x >> (WORD_W - n));
    endfunction
endpackage

// File: rtl/salsa_qr.sv
module salsa_qr
    import salsa_pkg::*;
(
    input  word_t a_i,
    input  word_t b_i,
    input  word_t c_i,
    input  word_t d_i,
    output word_t a_o,
    output word_t b_o,
    output word_t c_o,
    output word_t d_o
);
    word_t sum_ad, sum_ba, sum_cb, sum_dc;

    // Serial dependency: each step consumes the freshly updated word.
    assign sum_ad = a_i + d_i;
    assign b_o    = b_i ^ rotl(sum_ad, 7);
    assign sum_ba = b_o + a_i;
    assign c_o    = c_i ^ rotl(sum_ba, 9);
    assign sum_cb = c_o + b_o;
    assign d_o    = d_i ^ rotl(sum_cb, 13);
    assign sum_dc = d_o + c_o;
    assign a_o    = a_i ^ rotl(sum_dc, 18);
endmodule

// File: rtl/salsa_qr_layer.sv
module salsa_qr_layer
    import salsa_pkg::*;
(
    input  grid_t g_i,
    output grid_t g_o
);
    // One quarter-round unit per lane column; lane rows are operands a,b,c,d.
    for (genvar c = 0; c < LANES; c++) begin : g_col
        salsa_qr u_qr (
            .a_i (g_i[0][c]),
            .b_i (g_i[1][c]),
            .c_i (g_i[2][c]),
            .d_i (g_i[3][c]),
            .a_o (g_o[0][c]),
            .b_o (g_o[1][c]),
            .c_o (g_o[2][c]),
            .d_o (g_o[3][c])
        );
    end
endmodule

// File: rtl/salsa_dround.sv
module salsa_dround
    import salsa_pkg::*;
(
    input  grid_t lanes_i,
    output grid_t lanes_o
);
    grid_t col_o, row_i, row_o;

    salsa_qr_layer u_col (.g_i(lanes_i), .g_o(col_o));

    // Rotate lane k by k positions and reorder operands to (L0, L3, L2, L1),
    // so the same layer computes the row half-round; then undo both.
    for (genvar c = 0; c < LANES; c++) begin : g_rot
        localparam int C1 = (c + 1) % LANES;
        localparam int C2 = (c + 2) % LANES;
        localparam int C3 = (c + 3) % LANES;
        assign row_i[0][c]  = col_o[0][c];
        assign row_i[1][c]  = col_o[3][C1];
        assign row_i[2][c]  = col_o[2][C2];
        assign row_i[3][c]  = col_o[1][C3];
        assign lanes_o[0][c]  = row_o[0][c];
        assign lanes_o[3][C1] = row_o[1][c];
        assign lanes_o[2][C2] = row_o[2][c];
        assign lanes_o[1][C3] = row_o[3][c];
    end

    salsa_qr_layer u_row (.g_i(row_i), .g_o(row_o));
endmodule

// File: rtl/salsa_core_engine.sv
module salsa_core_engine
    import salsa_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] rounds,
    input  logic [511:0]     state_in,
    output logic             busy,
    output logic             done,
    output logic [511:0]     state_out
);
    typedef enum logic [1:0] {S_IDLE, S_RUN, S_FINISH} st_t;

    localparam logic [CNT_W-1:0] PAIRS_DEF = CNT_W'(10);

    st_t              state_q, state_d;
    grid_t            lanes_q, lanes_perm, lanes_next;
    logic [BLK_W-1:0] orig_q, sum_out, out_q;
    logic [CNT_W-1:0] pairs_q;
    logic             done_q;

    function automatic logic [CNT_W-1:0] pairs_for(input logic [CNT_W-1:0] r);
        if (r == CNT_W'(8) || r == CNT_W'(12) || r == CNT_W'(20))
            return r >> 1;
        return PAIRS_DEF;
    endfunction

    // Diagonal layout: lane r, column c holds matrix word at row (r+c)%4, column c.
    for (genvar r = 0; r < LANES; r++) begin : g_row
        for (genvar c = 0; c < LANES; c++) begin : g_col
            localparam int W = LANES * ((r + c) % LANES) + c;
            assign lanes_perm[r][c]             = state_in[WORD_W*W +: WORD_W];
            assign sum_out[WORD_W*W +: WORD_W]  = lanes_q[r][c] + orig_q[WORD_W*W +: WORD_W];
        end
    end

    salsa_dround u_dr (.lanes_i(lanes_q), .lanes_o(lanes_next));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start) state_d = S_RUN;
            S_RUN:    if (pairs_q == CNT_W'(1)) state_d = S_FINISH;
            S_FINISH: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lanes_q <= '0;
            orig_q  <= '0;
            out_q   <= '0;
            pairs_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                S_IDLE: begin
                    if (start) begin
                        orig_q  <= state_in;
                        lanes_q <= lanes_perm;
                        pairs_q <= pairs_for(rounds);
                    end
                end
                S_RUN: begin
                    lanes_q <= lanes_next;
                    pairs_q <= pairs_q - CNT_W'(1);
                end
                S_FINISH: begin
                    out_q  <= sum_out;
                    done_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign busy      = (state_q != S_IDLE);
    assign done      = done_q;
    assign state_out = out_q;
endmodule

// File: rtl/salsa_core_engine_chk.sv
module salsa_core_engine_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic [511:0] state_out
);
    assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy));

    assert_start_accepted_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    assert_idle_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> !busy);

    assert_out_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(state_out));
endmodule

bind salsa_core_engine salsa_core_engine_chk u_chk (.*);

// File: tb/salsa_core_engine_test.sv
module salsa_core_engine_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [4:0]   rounds = 5'd20;
    logic [511:0] state_in = '0;
    logic         busy, done;
    logic [511:0] state_out;

    int    checks = 0;
    int    failures = 0;
    string tag = "R1";
    logic [31:0] seed = 32'h1234_5678;

    // Model state
    int           m_cnt = 0;
    logic         exp_done = 1'b0;
    logic [511:0] exp_out = '0;
    logic [511:0] pend = '0;
    bit           armed = 0;

    always #4 clk = ~clk;

    salsa_core_engine uut (.*);

    function automatic logic [31:0] rl(input logic [31:0] x, input int n);
        return (x << n) | (x >> (32 - n));
    endfunction

    function automatic logic [127:0] qr_ref(input logic [31:0] a, b, c, d);
        b ^= rl(a + d, 7);
        c ^= rl(b + a, 9);
        d ^= rl(c + b, 13);
        a ^= rl(d + c, 18);
        return {a, b, c, d};
    endfunction

    function automatic logic [511:0] core_ref(input logic [511:0] blk, input int r);
        logic [31:0] x [16];
        logic [127:0] q;
        logic [511:0] res;
        int idx [4];
        for (int i = 0; i < 16; i++) x[i] = blk[32*i +: 32];
        for (int dr = 0; dr < r / 2; dr++) begin
            for (int h = 0; h < 2; h++) begin
                for (int j = 0; j < 4; j++) begin
                    for (int k = 0; k < 4; k++)
                        idx[k] = (h == 0) ? ((5*j + 4*k) % 16) : (4*j + (j + k) % 4);
                    q = qr_ref(x[idx[0]], x[idx[1]], x[idx[2]], x[idx[3]]);
                    {x[idx[0]], x[idx[1]], x[idx[2]], x[idx[3]]} = q;
                end
            end
        end
        for (int i = 0; i < 16; i++) res[32*i +: 32] = x[i] + blk[32*i +: 32];
        return res;
    endfunction

    function automatic int clamp(input int r);
        return (r == 8 || r == 12 || r == 20) ? r : 20;
    endfunction

    task automatic rand_block(output logic [511:0] b);
        for (int i = 0; i < 16; i++) begin
            seed = seed * 32'd1664525 + 32'd1013904223;
            b[32*i +: 32] = seed ^ {seed[15:0], seed[31:16]};
        end
    endtask

    // Reference model: advances on the same edge the design samples its inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; exp_done = 0; exp_out = '0;
        end else begin
            exp_done = 0;
            if (m_cnt > 0) begin
                m_cnt--;
                if (m_cnt == 0) begin exp_done = 1; exp_out = pend; end
            end else if (start) begin
                m_cnt = clamp(int'(rounds)) / 2 + 1;
                pend  = core_ref(state_in, clamp(int'(rounds)));
            end
        end
        armed = 1;
    end

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (armed) begin
            checks++;
            if (busy !== (m_cnt > 0) || done !== exp_done || state_out !== exp_out) begin
                failures++;
                $display("FAIL %s t=%0t busy=%b/%b done=%b/%b out=%h exp=%h",
                         tag, $time, busy, (m_cnt > 0), done, exp_done, state_out, exp_out);
            end
        end
    end

    task automatic run(input logic [511:0] blk, input int r);
        @(posedge clk); #1;
        start = 1'b1; state_in = blk; rounds = 5'(r);
        @(posedge clk); #1;
        start = 1'b0;
        repeat (clamp(r) / 2 + 3) @(posedge clk);
    endtask

    task automatic finish_up();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        logic [511:0] blk, blk2;
        logic [127:0] q;
        // R2: model sanity against the published quarter-round vector.
        q = qr_ref(32'h1, 32'h0, 32'h0, 32'h0);
        checks++;
        if (q !== {32'h08008145, 32'h00000080, 32'h00010200, 32'h20500000}) begin
            failures++;
            $display("FAIL R2 model quarter round got=%h exp=08008145000000800001020020500000", q);
        end

        tag = "R1";
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (3) @(posedge clk);

        tag = "R2";          // published vector: all-zero block maps to zero
        run('0, 20);
        tag = "R2_R9";       // word order through random blocks
        for (int i = 0; i < 3; i++) begin rand_block(blk); run(blk, 20); end
        blk = '0; blk[31:0] = 32'h1; run(blk, 20);

        tag = "R3";
        rand_block(blk); run(blk, 8);
        rand_block(blk); run(blk, 12);

        tag = "R4";
        rand_block(blk); run(blk, 0);
        rand_block(blk); run(blk, 7);
        rand_block(blk); run(blk, 10);
        rand_block(blk); run(blk, 31);

        tag = "R8";          // inputs change right after start
        rand_block(blk); rand_block(blk2);
        @(posedge clk); #1;
        start = 1'b1; state_in = blk; rounds = 5'd12;
        @(posedge clk); #1;
        start = 1'b0; state_in = blk2; rounds = 5'd8;
        repeat (10) @(posedge clk);

        tag = "R6_R7";       // start held high: ignored while busy, re-accepted on done
        rand_block(blk); rand_block(blk2);
        @(posedge clk); #1;
        start = 1'b1; state_in = blk; rounds = 5'd8;
        repeat (3) @(posedge clk); #1;
        state_in = blk2; rounds = 5'd20;
        repeat (25) @(posedge clk); #1;
        start = 1'b0;
        repeat (15) @(posedge clk);

        finish_up();
    end
endmodule